// File: doc/BRIEF.md
# Timer Event Interrupt Flag Unit

This block is a 16-bit timer/counter that records its events in an 8-bit interrupt flag register. Three compare channels (A, B, C) each watch the counter against their own compare value. A capture channel copies the counter when an edge arrives on a capture pin. An overflow event fires when the counter passes its all-ones value. Each event sets its own flag. The flag stays set until software writes a one to that bit position, or until the interrupt controller acknowledges that source.

The counter runs in one of three waveform modes:
- a free-running mode that wraps at all-ones;
- a clear-on-match mode whose top is compare A;
- a clear-on-match mode whose top is the capture register.

In the last mode the capture flag marks "top reached" rather than a pin edge. A one-cycle `tick` input acts as the timer clock enable. Each flag produces its own interrupt request, gated by an enable bit at the same position.

Top module: `tmr_evt_unit`

## Requirements
- R1: The flag register places overflow at bit 0, compare A at bit 1, compare B at bit 2, compare C at bit 3 and capture at bit 5. Bits 7, 6 and 4 always read 0, and writing them has no effect.
- R2: A synchronous reset clears the flags, the counter and the capture register to 0.
- R3: `mode_sel` chooses the counter behaviour: 0 is free-running, 1 clears on compare A, 2 clears on the capture register, and 3 behaves as 0.
  - On each cycle with `tick`=1 the counter steps by one.
  - In free-running mode it wraps from 0xFFFF to 0.
  - In modes 1 and 2 it goes to 0 on the tick taken while it equals the selected top.
- R4: A compare flag is set by the clock edge of a tick taken while the counter equals that channel's compare value. The flag is therefore visible from the cycle after the matching count.
- R5: A pulse on `force_cmp[k]` never sets compare flag k.
- R6: Outside mode 2, a capture pin edge sets flag bit 5 and copies the counter into the capture register.
  - `cap_rise`=1 selects rising edges; `cap_rise`=0 selects falling edges.
  - The pin passes through a two-flop synchronizer, so the flag and the copy appear on the third clock edge after the pin changes.
- R7: In mode 2, flag bit 5 is set by a tick taken while the counter equals the capture register. Pin edges then neither set the flag nor change the capture register.
- R8: The overflow flag is set by a tick taken while the counter equals 0xFFFF.
- R9: A register write with `flag_wr_en`=1 clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R10: A one-cycle pulse on `irq_ack[i]` clears flag i.
- R11: If a set event and a clear (write or acknowledge) reach the same flag in one cycle, the flag ends up set.
- R12: `irq[i]` is 1 exactly while flag i is set and `irq_en[i]` is 1.
- R13: `cap_wr_en` loads `cap_wr_data` into the capture register. This write takes precedence over a capture copy in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| mode_sel | input | 2 | Counter mode select |
| cap_rise | input | 1 | Capture edge polarity (1 = rising) |
| cap_pin | input | 1 | Asynchronous capture input |
| cmp_a | input | 16 | Compare A value (also the mode-1 top) |
| cmp_b | input | 16 | Compare B value |
| cmp_c | input | 16 | Compare C value |
| cap_wr_en | input | 1 | Capture register write strobe |
| cap_wr_data | input | 16 | Capture register write data |
| force_cmp | input | 3 | Forced-compare strobes for C, B, A (bits 2..0) |
| flag_wr_en | input | 1 | Flag register write strobe |
| flag_wr_data | input | 8 | Flag write data (a one clears that flag) |
| irq_en | input | 8 | Per-flag interrupt enables |
| irq_ack | input | 8 | Per-flag acknowledge pulses |
| count | output | 16 | Counter value |
| cap_val | output | 16 | Capture register value |
| flags | output | 8 | Interrupt flag register |
| irq | output | 8 | Per-flag interrupt requests |

## Verification
The two functions that can meet in one cycle are setting a flag and clearing it. The bench provokes this by taking a tick while the counter equals compare A. In that same cycle it drives a write of one to bit 1 and an acknowledge pulse on bit 1. The flag must read set afterwards. A further acknowledge in a cycle with no event must then clear it.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_CLR_A    = 2'd1,
    MODE_CLR_CAP  = 2'd2,
    MODE_FREE_ALT = 2'd3
  } tmr_mode_e;

  localparam int FLAG_W  = 8;
  localparam int BIT_OVF = 0;
  localparam int BIT_CA  = 1;
  localparam int BIT_CB  = 2;
  localparam int BIT_CC  = 3;
  localparam int BIT_CAP = 5;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 8'b0010_1111;
endpackage

// File: rtl/tmr_evt_counter.sv
module tmr_evt_counter
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCMP  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  tmr_mode_e                  mode,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_vals,
  input  logic [CNT_W-1:0]           cap_top,
  output logic [CNT_W-1:0]           cnt,
  output logic [NCMP-1:0]            cmp_hit,
  output logic                       ovf_hit,
  output logic                       cap_top_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_top;

  always_comb begin
    case (mode)
      MODE_CLR_A:   at_top = (cnt == cmp_vals[0]);
      MODE_CLR_CAP: at_top = (cnt == cap_top);
      default:      at_top = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= at_top ? '0 : cnt + 1'b1;
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign cmp_hit[g] = tick && (cnt == cmp_vals[g]);
  end

  assign ovf_hit     = tick && (cnt == CNT_MAX);
  assign cap_top_hit = tick && (mode == MODE_CLR_CAP) && (cnt == cap_top);

  assert_clr_a_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == MODE_CLR_A && cnt == cmp_vals[0]) |=> (cnt == '0));
  assert_free_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == MODE_FREE && cnt != CNT_MAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/tmr_evt_capture.sv
module tmr_evt_capture #(
  parameter int CNT_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_pin,
  input  logic             cap_rise,
  input  logic             enable,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cap_reg,
  output logic             cap_evt
);
  // sh[SYNC-1] is the synchronized level, sh[SYNC] its previous value
  logic [SYNC:0] sh;
  logic          lvl, prv, edge_seen;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], cap_pin};
  end

  assign lvl       = sh[SYNC-1];
  assign prv       = sh[SYNC];
  assign edge_seen = cap_rise ? (lvl & ~prv) : (~lvl & prv);
  assign cap_evt   = edge_seen && enable;

  always_ff @(posedge clk) begin
    if (rst)          cap_reg <= '0;
    else if (wr_en)   cap_reg <= wr_data;
    else if (cap_evt) cap_reg <= cnt;
  end

  assert_cap_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && !wr_en) |=> (cap_reg == $past(cnt)));
  assert_cap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!enable && !wr_en) |=> $stable(cap_reg));
  assert_cap_load_R13: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cap_reg == $past(wr_data)));
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tmr_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] ack,
  input  logic [FLAG_W-1:0] en,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] irq
);
  logic [FLAG_W-1:0] clr, nxt;

  always_comb begin
    clr = ack | (wr_en ? wr_data : '0);
    nxt = ((flags & ~clr) | set_vec) & FLAG_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= nxt;
  end

  assign irq = flags & en;

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (flags & ~FLAG_MASK) == '0);

  for (genvar i = 0; i < FLAG_W; i++) begin : g_chk
    if (FLAG_MASK[i]) begin : g_valid
      assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> flags[i]);
      assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[i] && !set_vec[i]) |=> !flags[i]);
      assert_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (ack[i] && !set_vec[i]) |=> !flags[i]);
      assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr[i] && !set_vec[i]) |=> $stable(flags[i]));
    end
  end
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       mode_sel,
  input  logic             cap_rise,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] cmp_c,
  input  logic             cap_wr_en,
  input  logic [CNT_W-1:0] cap_wr_data,
  input  logic [2:0]       force_cmp,
  input  logic             flag_wr_en,
  input  logic [7:0]       flag_wr_data,
  input  logic [7:0]       irq_en,
  input  logic [7:0]       irq_ack,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_val,
  output logic [7:0]       flags,
  output logic [7:0]       irq
);
  localparam int NCMP = 3;

  tmr_mode_e                  mode;
  logic [NCMP-1:0][CNT_W-1:0] cmp_vals;
  logic [NCMP-1:0]            cmp_hit;
  logic                       ovf_hit, cap_top_hit, cap_evt;
  logic [FLAG_W-1:0]          set_vec;

  assign mode     = tmr_mode_e'(mode_sel);
  assign cmp_vals = {cmp_c, cmp_b, cmp_a};

  tmr_evt_counter #(.CNT_W(CNT_W), .NCMP(NCMP)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .cmp_vals(cmp_vals),
    .cap_top(cap_val), .cnt(count), .cmp_hit(cmp_hit), .ovf_hit(ovf_hit),
    .cap_top_hit(cap_top_hit)
  );

  tmr_evt_capture #(.CNT_W(CNT_W), .SYNC(SYNC)) u_cap (
    .clk(clk), .rst(rst), .cap_pin(cap_pin), .cap_rise(cap_rise),
    .enable(mode != MODE_CLR_CAP), .cnt(count), .wr_en(cap_wr_en),
    .wr_data(cap_wr_data), .cap_reg(cap_val), .cap_evt(cap_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_OVF] = ovf_hit;
    set_vec[BIT_CA]  = cmp_hit[0];
    set_vec[BIT_CB]  = cmp_hit[1];
    set_vec[BIT_CC]  = cmp_hit[2];
    set_vec[BIT_CAP] = cap_evt | cap_top_hit;
  end

  tmr_evt_flags u_flg (
    .clk(clk), .rst(rst), .set_vec(set_vec), .wr_en(flag_wr_en),
    .wr_data(flag_wr_data), .ack(irq_ack), .en(irq_en), .flags(flags), .irq(irq)
  );

  for (genvar k = 0; k < NCMP; k++) begin : g_force_chk
    assert_force_noset_R5: assert property (@(posedge clk) disable iff (rst)
      (force_cmp[k] && !(tick && count == cmp_vals[k]) && !flags[BIT_CA+k])
      |=> !flags[BIT_CA+k]);
  end

  assert_cmp_a_set_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && count == cmp_a) |=> flags[BIT_CA]);
  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && count == '1) |=> flags[BIT_OVF]);
  assert_top_cap_set_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_sel == 2'd2 && count == cap_val) |=> flags[BIT_CAP]);
  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (rst)
    irq == (flags & irq_en));
endmodule

// File: tb/tb_tmr_evt_unit.sv
module tb_tmr_evt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        cap_rise = 1'b1;
  logic        cap_pin = 1'b0;
  logic [15:0] cmp_a = 16'h0100, cmp_b = 16'h0100, cmp_c = 16'h0100;
  logic        cap_wr_en = 1'b0;
  logic [15:0] cap_wr_data = '0;
  logic [2:0]  force_cmp = '0;
  logic        flag_wr_en = 1'b0;
  logic [7:0]  flag_wr_data = '0;
  logic [7:0]  irq_en = '0;
  logic [7:0]  irq_ack = '0;
  logic [15:0] count, cap_val;
  logic [7:0]  flags, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_evt_unit dut (
    .clk(clk), .rst(rst), .tick(tick), .mode_sel(mode_sel), .cap_rise(cap_rise),
    .cap_pin(cap_pin), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
    .cap_wr_en(cap_wr_en), .cap_wr_data(cap_wr_data), .force_cmp(force_cmp),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data), .irq_en(irq_en),
    .irq_ack(irq_ack), .count(count), .cap_val(cap_val), .flags(flags), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] ca;
    logic [15:0] top;
    logic [15:0] n;
    logic [15:0] ecnt;
    logic [7:0]  eflg;
  } row_t;

  localparam int NROWS = 7;
  localparam row_t ROWS [NROWS] = '{
    '{2'd0, 16'd3,     16'd0, 16'd5,  16'd5, 8'h02},
    '{2'd1, 16'd3,     16'd0, 16'd10, 16'd2, 8'h02},
    '{2'd2, 16'h0100,  16'd4, 16'd10, 16'd0, 8'h20},
    '{2'd3, 16'h0100,  16'd0, 16'd7,  16'd7, 8'h00},
    '{2'd1, 16'd0,     16'd0, 16'd5,  16'd0, 8'h02},
    '{2'd0, 16'd2,     16'd0, 16'd2,  16'd2, 8'h00},
    '{2'd0, 16'd2,     16'd0, 16'd3,  16'd3, 8'h02}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic w1c(input logic [7:0] d);
    flag_wr_en = 1'b1; flag_wr_data = d;
    step(1);
    flag_wr_en = 1'b0; flag_wr_data = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    rst = 1'b0;
    // R2 reset state
    chk("R2 flags", {8'h0, flags}, 16'h0);
    chk("R2 count", count, 16'h0);
    chk("R2 cap_val", cap_val, 16'h0);
    chk("R2 irq", {8'h0, irq}, 16'h0);

    // Vector table: R3 counter modes, R4 compare timing, R7 top flag
    for (int r = 0; r < NROWS; r++) begin
      rst = 1'b1;
      mode_sel = ROWS[r].mode; cmp_a = ROWS[r].ca;
      cmp_b = 16'h0100; cmp_c = 16'h0100;
      step(1);
      rst = 1'b0;
      cap_wr_en = 1'b1; cap_wr_data = ROWS[r].top;
      step(1);
      cap_wr_en = 1'b0;
      tick = 1'b1;
      step(int'(ROWS[r].n));
      tick = 1'b0;
      chk($sformatf("R3 row%0d count", r), count, ROWS[r].ecnt);
      chk($sformatf("R4 R7 row%0d flags", r), {8'h0, flags}, {8'h0, ROWS[r].eflg});
    end

    // R8 overflow with R4 compare B at the same count
    mode_sel = 2'd0; cmp_a = 16'h0100; cmp_b = 16'hFFFF; cmp_c = 16'h0100;
    do_reset();
    tick = 1'b1;
    step(65535);
    tick = 1'b0;
    chk("R3 count at max", count, 16'hFFFF);
    chk("R8 no overflow before wrap", {15'h0, flags[0]}, 16'h0);
    w1c(8'hFF);
    chk("R9 clear all", {8'h0, flags}, 16'h0);
    tick = 1'b1;
    step(1);
    tick = 1'b0;
    chk("R3 wrap to zero", count, 16'h0);
    chk("R8 R4 overflow and compare B", {8'h0, flags}, 16'h0005);

    // R9 write-one-to-clear, R1 reserved bits
    w1c(8'h01);
    chk("R9 clear bit0 only", {8'h0, flags}, 16'h0004);
    w1c(8'h00);
    chk("R9 zero write keeps", {8'h0, flags}, 16'h0004);
    w1c(8'hD0);
    chk("R1 reserved write no effect", {8'h0, flags}, 16'h0004);

    // R12 interrupt gating
    irq_en = 8'hFF;
    step(1);
    chk("R12 irq enabled", {8'h0, irq}, 16'h0004);
    irq_en = 8'h00;
    step(1);
    chk("R12 irq masked", {8'h0, irq}, 16'h0000);

    // R10 acknowledge clear
    irq_ack = 8'h04;
    step(1);
    irq_ack = 8'h00;
    chk("R10 ack clears", {8'h0, flags}, 16'h0000);

    // R11 set wins over simultaneous write and ack
    cmp_a = 16'd0; cmp_b = 16'h0100;
    do_reset();
    tick = 1'b1; flag_wr_en = 1'b1; flag_wr_data = 8'h02; irq_ack = 8'h02;
    step(1);
    tick = 1'b0; flag_wr_en = 1'b0; flag_wr_data = '0; irq_ack = '0;
    chk("R11 set wins", {8'h0, flags}, 16'h0002);
    irq_ack = 8'h02;
    step(1);
    irq_ack = '0;
    chk("R10 ack after", {8'h0, flags}, 16'h0000);

    // R5 forced compare never sets a flag
    force_cmp = 3'b111; tick = 1'b1;
    step(1);
    force_cmp = '0; tick = 1'b0;
    chk("R5 force with tick", {8'h0, flags}, 16'h0000);
    cmp_b = count;
    force_cmp = 3'b010;
    step(1);
    force_cmp = '0;
    chk("R5 force at matching count", {8'h0, flags}, 16'h0000);

    // R6 capture on rising edge, latency and copied value
    cmp_a = 16'h0100; cmp_b = 16'h0100; cmp_c = 16'h0100; mode_sel = 2'd0;
    cap_rise = 1'b1; cap_pin = 1'b0;
    do_reset();
    tick = 1'b1;
    step(6);
    tick = 1'b0;
    cap_pin = 1'b1;
    step(2);
    chk("R6 not yet captured", {8'h0, flags}, 16'h0000);
    step(1);
    chk("R6 rising capture flag", {8'h0, flags}, 16'h0020);
    chk("R6 rising capture value", cap_val, 16'd6);
    // falling polarity
    w1c(8'h20);
    cap_rise = 1'b0;
    tick = 1'b1;
    step(3);
    tick = 1'b0;
    cap_pin = 1'b0;
    step(3);
    chk("R6 falling capture flag", {8'h0, flags}, 16'h0020);
    chk("R6 falling capture value", cap_val, 16'd9);
    w1c(8'h20);
    cap_pin = 1'b1;
    step(4);
    chk("R6 rising ignored when falling", {8'h0, flags}, 16'h0000);
    chk("R6 value kept", cap_val, 16'd9);

    // R7 mode 2 ignores pin, R13 software load
    cap_pin = 1'b0; cap_rise = 1'b1;
    do_reset();
    cap_wr_en = 1'b1; cap_wr_data = 16'h0050;
    step(1);
    cap_wr_en = 1'b0;
    chk("R13 capture load", cap_val, 16'h0050);
    mode_sel = 2'd2;
    cap_pin = 1'b1;
    step(4);
    chk("R7 pin ignored flag", {8'h0, flags}, 16'h0000);
    chk("R7 pin ignored value", cap_val, 16'h0050);
    mode_sel = 2'd0;
    cap_pin = 1'b0;
    step(3);
    cap_pin = 1'b1;
    step(3);
    chk("R6 capture resumes flag", {8'h0, flags}, 16'h0020);
    chk("R6 capture resumes value", cap_val, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule